// File: doc/BRIEF.md
# Byte-Wide One-Time-Programmable Memory Model

This block is a clocked, synthesizable stand-in for a byte-wide programmable read-only memory. It gives a test environment a target that behaves like the real part at the level of its control lines. A 16-bit address, an active-low chip enable, an active-low output enable and two level flags select what the part does. The flags are one for programming supply present and one for a high voltage on address line 9. Together these pick one of six modes: read, output disable, standby, program, program inhibit and identifier readout. The bidirectional data bus is split into an input, an output and an output-enable, so a pad wrapper or a bench can recombine it.

Storage comes up erased, with every bit at 1. A program cycle can only clear bits. The new byte is the stored byte ANDed with the incoming data, and the write is committed when chip enable returns high. Only the bulk-erase input, provided for testing, brings bits back to 1. Storage depth is set by a parameter so that simulations can use a small array. Address bits above the array index are ignored. Every response is registered: the bus reflects the inputs sampled at one clock edge right after that edge. An error flag reports control combinations that the mode table does not allow.

Top module: `otp_bytemem`

## Requirements
- R1: After reset the bus is not driven (data_oe 0, data_out 0, mode_err 0), and every byte reads 0xFF.
- R2: With chip_en_n 0, out_en_n 0, prog_hv 0 and id_hv 0 sampled at a clock edge, data_oe is 1 after that edge and data_out is the stored byte at the address.
- R3: With chip_en_n 0, prog_hv 0 and out_en_n 1, data_oe and data_out are both 0 after the edge.
- R4: With chip_en_n 1, data_oe is 0 after the edge, whatever out_en_n, prog_hv and id_hv are.
- R5: Program mode is chip_en_n 0 with prog_hv 1. The address and data_in are sampled at every such edge. At the first edge where chip_en_n is seen 1 again, the byte at the last sampled address becomes its old value AND the last sampled data. The bus stays undriven during program mode.
- R6: With prog_hv 1 and chip_en_n held 1, no byte changes and the bus is not driven.
- R7: Programming never sets a bit. A 1 in data_in over a stored 0 leaves that 0.
- R8: Identifier mode is chip_en_n 0, out_en_n 0, prog_hv 0 and id_hv 1. In this mode the part drives 0x20 when addr[0] is 0 and 0x3D when addr[0] is 1, in place of the stored data.
- R9: When prog_hv and id_hv are both 1 with chip_en_n 0, program mode wins: the bus is undriven, the write still commits, and mode_err is 1 after the edge.
- R10: In identifier mode, any 1 on an address bit other than bit 0 and bit 9 sets mode_err after the edge. All modes in R2 to R8 otherwise leave mode_err 0.
- R11: erase_all sampled 1 at an edge sets every byte to 0xFF at that edge, and it overrides a program commit at the same edge.
- R12: Only the low DEPTH_LOG2 address bits select a byte; addresses that differ only above them reach the same byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Model clock; all sampling and state changes at its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset; restores the erased state |
| addr | input | 16 | Byte address |
| chip_en_n | input | 1 | Active-low chip enable; high means standby or program inhibit |
| out_en_n | input | 1 | Active-low output enable |
| prog_hv | input | 1 | Programming supply present |
| id_hv | input | 1 | High voltage present on address line 9 |
| data_in | input | 8 | Data pins as seen by the part when the bus is not driven |
| data_out | output | 8 | Data the part drives; 0 when not driving |
| data_oe | output | 1 | 1 when the part drives the bus |
| erase_all | input | 1 | Test-only bulk erase to all ones |
| mode_err | output | 1 | Illegal control combination seen at the last edge |

## Verification
A corrupted stored byte stays hidden until that byte is read. It then shows up on data_out exactly one edge after the read is sampled, so the bench mirrors every byte and reads back both the target byte and a random one. A bad program latch shows up as a write to the wrong byte or with the wrong data. A missing commit leaves the old value. Both are seen at the first read after chip enable returns high. A wrong mode decode shows up one edge after the controls change, as a driven bus in standby or disable, as data in place of an identifier, or as a wrong mode_err.

// File: rtl/otp_pkg.sv
package otp_pkg;

    typedef enum logic [2:0] {
        MODE_STANDBY = 3'd0,
        MODE_INHIBIT = 3'd1,
        MODE_DISABLE = 3'd2,
        MODE_READ    = 3'd3,
        MODE_IDENT   = 3'd4,
        MODE_PROGRAM = 3'd5
    } otp_mode_e;

    localparam logic [7:0] ID_MAKER  = 8'h20;
    localparam logic [7:0] ID_DEVICE = 8'h3D;

    // Address lines that may be high while identifier codes are read
    localparam int ID_SEL_BIT = 0;
    localparam int ID_HV_BIT  = 9;

endpackage

// File: rtl/otp_mode_dec.sv
module otp_mode_dec
    import otp_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic              chip_en_n,
    input  logic              out_en_n,
    input  logic              prog_hv,
    input  logic              id_hv,
    input  logic [ADDR_W-1:0] addr,
    output otp_mode_e         mode,
    output logic              illegal
);

    localparam logic [ADDR_W-1:0] FREE_MASK =
        (ADDR_W'(1) << ID_SEL_BIT) | (ADDR_W'(1) << ID_HV_BIT);

    always_comb begin
        mode    = MODE_STANDBY;
        illegal = 1'b0;
        if (chip_en_n) begin
            mode = prog_hv ? MODE_INHIBIT : MODE_STANDBY;
        end else if (prog_hv) begin
            mode    = MODE_PROGRAM;
            illegal = id_hv;
        end else if (out_en_n) begin
            mode = MODE_DISABLE;
        end else if (id_hv) begin
            mode    = MODE_IDENT;
            illegal = |(addr & ~FREE_MASK);
        end else begin
            mode = MODE_READ;
        end
    end

endmodule

// File: rtl/otp_prog_seq.sv
module otp_prog_seq #(
    parameter int IDX_W  = 8,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              chip_en_n,
    input  logic              prog_hv,
    input  logic [IDX_W-1:0]  idx,
    input  logic [DATA_W-1:0] data_in,
    output logic              commit,
    output logic [IDX_W-1:0]  wr_idx,
    output logic [DATA_W-1:0] wr_data
);

    typedef struct packed {
        logic              armed;
        logic [IDX_W-1:0]  idx;
        logic [DATA_W-1:0] data;
    } seq_t;

    seq_t seq_d, seq_q;

    always_comb begin
        seq_d       = seq_q;
        seq_d.armed = !chip_en_n && prog_hv;
        if (!chip_en_n && prog_hv) begin
            seq_d.idx  = idx;
            seq_d.data = data_in;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q <= '0;
        end else begin
            seq_q <= seq_d;
        end
    end

    assign commit  = seq_q.armed && chip_en_n;
    assign wr_idx  = seq_q.idx;
    assign wr_data = seq_q.data;

    // R5
    commit_after_prog_chk: assert property (@(posedge clk) disable iff (!rst_n)
        commit |-> $past(!chip_en_n && prog_hv));

endmodule

// File: rtl/otp_cell_array.sv
module otp_cell_array #(
    parameter int IDX_W  = 8,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              erase_all,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [DATA_W-1:0] rd_data
);

    localparam int DEPTH = 1 << IDX_W;

    logic [DATA_W-1:0] mem_d [DEPTH];
    logic [DATA_W-1:0] mem_q [DEPTH];

    always_comb begin
        mem_d = mem_q;
        if (erase_all) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem_d[i] = '1;
            end
        end else if (wr_en) begin
            mem_d[wr_idx] = mem_q[wr_idx] & wr_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem_q[i] <= '1;
            end
        end else begin
            mem_q <= mem_d;
        end
    end

    assign rd_data = mem_q[rd_idx];

    // R7
    only_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && !erase_all |=> ((mem_q[$past(wr_idx)] & ~$past(wr_data)) == '0));

    // R11
    erase_ones_chk: assert property (@(posedge clk) disable iff (!rst_n)
        erase_all |=> (rd_data == '1));

endmodule

// File: rtl/otp_bytemem.sv
module otp_bytemem
    import otp_pkg::*;
#(
    parameter int ADDR_W     = 16,
    parameter int DATA_W     = 8,
    parameter int DEPTH_LOG2 = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              chip_en_n,
    input  logic              out_en_n,
    input  logic              prog_hv,
    input  logic              id_hv,
    input  logic [DATA_W-1:0] data_in,
    output logic [DATA_W-1:0] data_out,
    output logic              data_oe,
    input  logic              erase_all,
    output logic              mode_err
);

    localparam int IDX_W = (DEPTH_LOG2 < ADDR_W) ? DEPTH_LOG2 : ADDR_W;

    typedef struct packed {
        logic [DATA_W-1:0] dout;
        logic              oe;
        logic              err;
    } bus_t;

    otp_mode_e         mode;
    logic              illegal;
    logic              commit;
    logic [IDX_W-1:0]  wr_idx;
    logic [DATA_W-1:0] wr_data;
    logic [DATA_W-1:0] rd_data;
    bus_t              bus_d, bus_q;

    otp_mode_dec #(.ADDR_W(ADDR_W)) u_dec (
        .chip_en_n (chip_en_n),
        .out_en_n  (out_en_n),
        .prog_hv   (prog_hv),
        .id_hv     (id_hv),
        .addr      (addr),
        .mode      (mode),
        .illegal   (illegal)
    );

    otp_prog_seq #(.IDX_W(IDX_W), .DATA_W(DATA_W)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .chip_en_n (chip_en_n),
        .prog_hv   (prog_hv),
        .idx       (addr[IDX_W-1:0]),
        .data_in   (data_in),
        .commit    (commit),
        .wr_idx    (wr_idx),
        .wr_data   (wr_data)
    );

    otp_cell_array #(.IDX_W(IDX_W), .DATA_W(DATA_W)) u_cells (
        .clk       (clk),
        .rst_n     (rst_n),
        .erase_all (erase_all),
        .wr_en     (commit),
        .wr_idx    (wr_idx),
        .wr_data   (wr_data),
        .rd_idx    (addr[IDX_W-1:0]),
        .rd_data   (rd_data)
    );

    always_comb begin
        bus_d      = '0;
        bus_d.err  = illegal;
        case (mode)
            MODE_READ: begin
                bus_d.oe   = 1'b1;
                bus_d.dout = rd_data;
            end
            MODE_IDENT: begin
                bus_d.oe   = 1'b1;
                bus_d.dout = addr[ID_SEL_BIT] ? DATA_W'(ID_DEVICE) : DATA_W'(ID_MAKER);
            end
            default: begin
                bus_d.oe   = 1'b0;
                bus_d.dout = '0;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bus_q <= '0;
        end else begin
            bus_q <= bus_d;
        end
    end

    assign data_out = bus_q.dout;
    assign data_oe  = bus_q.oe;
    assign mode_err = bus_q.err;

    // R4
    standby_hiz_chk: assert property (@(posedge clk) disable iff (!rst_n)
        chip_en_n |=> !data_oe);

    // R3
    disable_hiz_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !chip_en_n && out_en_n |=> !data_oe && (data_out == '0));

    // R2
    drive_only_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        data_oe |-> $past(!chip_en_n && !out_en_n && !prog_hv));

    // R8
    ident_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_IDENT) |=> data_oe &&
            (data_out == DATA_W'(ID_MAKER) || data_out == DATA_W'(ID_DEVICE)));

    // R9
    prog_priority_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !chip_en_n && prog_hv && id_hv |=> mode_err && !data_oe);

endmodule

// File: tb/otp_bytemem_bench.sv
module otp_bytemem_bench;

    localparam int DEPTH = 256;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] addr = '0;
    logic        chip_en_n = 1'b1;
    logic        out_en_n = 1'b1;
    logic        prog_hv = 1'b0;
    logic        id_hv = 1'b0;
    logic [7:0]  data_in = '0;
    logic [7:0]  data_out;
    logic        data_oe;
    logic        erase_all = 1'b0;
    logic        mode_err;

    int checks = 0;
    int errors = 0;
    bit done = 0;
    logic [7:0] model [DEPTH];

    always #2 clk = ~clk;

    otp_bytemem u_otp_bytemem (
        .clk(clk), .rst_n(rst_n), .addr(addr), .chip_en_n(chip_en_n),
        .out_en_n(out_en_n), .prog_hv(prog_hv), .id_hv(id_hv),
        .data_in(data_in), .data_out(data_out), .data_oe(data_oe),
        .erase_all(erase_all), .mode_err(mode_err)
    );

    function automatic logic [7:0] id_code(input logic a0);
        return a0 ? 8'h3D : 8'h20;
    endfunction

    task automatic check(input string req, input logic [8:0] act, input logic [8:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic idle();
        @(negedge clk);
        chip_en_n = 1'b1; out_en_n = 1'b1; prog_hv = 1'b0; id_hv = 1'b0; erase_all = 1'b0;
    endtask

    task automatic do_read(input logic [15:0] a, input string req);
        @(negedge clk);
        addr = a; chip_en_n = 1'b0; out_en_n = 1'b0; prog_hv = 1'b0; id_hv = 1'b0;
        @(negedge clk);
        check(req, {data_oe, data_out}, {1'b1, model[a[7:0]]});
        check({req, " err"}, {8'h00, mode_err}, 9'h000);
    endtask

    task automatic do_prog(input logic [15:0] a, input logic [7:0] d, input logic with_id);
        @(negedge clk);
        addr = a; data_in = d; chip_en_n = 1'b0; out_en_n = 1'b1;
        prog_hv = 1'b1; id_hv = with_id;
        @(negedge clk);
        check("R5 bus idle in program", {8'h00, data_oe}, 9'h000);
        if (with_id) check("R9 program wins, error", {8'h00, mode_err}, 9'h001);
        chip_en_n = 1'b1; id_hv = 1'b0; addr = ~a; data_in = 8'h00;
        @(negedge clk);
        model[a[7:0]] = model[a[7:0]] & d;
        prog_hv = 1'b0;
    endtask

    task automatic do_ident(input logic [15:0] a);
        @(negedge clk);
        addr = a; chip_en_n = 1'b0; out_en_n = 1'b0; prog_hv = 1'b0; id_hv = 1'b1;
        @(negedge clk);
        check("R8 identifier code", {data_oe, data_out}, {1'b1, id_code(a[0])});
        check("R10 identifier address error", {8'h00, mode_err},
              {8'h00, |(a & 16'hFDFE)});
    endtask

    task automatic do_standby(input logic oe, input logic vpp, input logic idf);
        @(negedge clk);
        chip_en_n = 1'b1; out_en_n = oe; prog_hv = vpp; id_hv = idf;
        @(negedge clk);
        check("R4 standby not driven", {8'h00, data_oe}, 9'h000);
    endtask

    initial begin
        int unsigned seed;
        seed = $urandom(32'd4099);
        for (int i = 0; i < DEPTH; i++) model[i] = 8'hFF;
        repeat (3) @(negedge clk);
        check("R1 reset bus", {data_oe, data_out}, 9'h000);
        check("R1 reset err", {8'h00, mode_err}, 9'h000);
        rst_n = 1'b1;
        do_read(16'h0000, "R1 erased byte");
        do_read(16'h00FF, "R1 erased byte");

        // output disable
        @(negedge clk);
        addr = 16'h0010; chip_en_n = 1'b0; out_en_n = 1'b1; prog_hv = 1'b0; id_hv = 1'b1;
        @(negedge clk);
        check("R3 disable", {data_oe, data_out}, 9'h000);
        check("R10 disable no error", {8'h00, mode_err}, 9'h000);

        do_standby(1'b0, 1'b0, 1'b0);
        do_standby(1'b0, 1'b0, 1'b1);

        // program and clear-only
        do_prog(16'h0012, 8'hA5, 1'b0);
        do_read(16'h0012, "R5 programmed");
        do_prog(16'h0012, 8'h5F, 1'b0);
        do_read(16'h0012, "R7 only clears");
        do_read(16'h0013, "R5 neighbour untouched");

        // inhibit
        @(negedge clk);
        addr = 16'h0040; data_in = 8'h00; chip_en_n = 1'b1; prog_hv = 1'b1; out_en_n = 1'b0;
        @(negedge clk);
        check("R6 inhibit not driven", {8'h00, data_oe}, 9'h000);
        @(negedge clk);
        prog_hv = 1'b0;
        do_read(16'h0040, "R6 inhibit no write");

        // identifier
        do_ident(16'h0000);
        do_ident(16'h0001);
        do_ident(16'h0201);
        do_ident(16'h0004);
        do_ident(16'h8001);

        // program priority over identifier
        do_prog(16'h0077, 8'h3C, 1'b1);
        do_read(16'h0077, "R9 program committed");

        // aliasing
        do_prog(16'h0105, 8'h0F, 1'b0);
        do_read(16'hA505, "R12 upper bits ignored");

        // erase, including erase against a commit
        @(negedge clk);
        addr = 16'h0030; data_in = 8'h00; chip_en_n = 1'b0; prog_hv = 1'b1; out_en_n = 1'b1;
        @(negedge clk);
        chip_en_n = 1'b1; erase_all = 1'b1;
        @(negedge clk);
        erase_all = 1'b0; prog_hv = 1'b0;
        for (int i = 0; i < DEPTH; i++) model[i] = 8'hFF;
        do_read(16'h0030, "R11 erase beats commit");
        do_read(16'h0012, "R11 erased");
        do_read(16'h0077, "R11 erased");

        // constrained random mix
        for (int n = 0; n < 400; n++) begin
            int op;
            logic [15:0] a;
            op = int'($urandom_range(0, 5));
            a = {8'($urandom()), 4'h0, 4'($urandom())};
            case (op)
                0, 1: do_prog(a, 8'($urandom()), 1'($urandom_range(0, 7) == 0));
                2: do_read(a, "R2 random read");
                3: do_ident({6'($urandom()), 1'b1, 8'h00, 1'($urandom())} & 16'h0201 |
                            ($urandom_range(0, 3) == 0 ? 16'h0010 : 16'h0000));
                4: do_standby(1'($urandom()), 1'($urandom()), 1'($urandom()));
                default: do_read(16'($urandom()), "R2 random read");
            endcase
        end
        idle();
        @(negedge clk);
        if (!done) begin
            done = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule